// File: doc/BRIEF.md
# Dual-Half Hamming ECC Generator

This block sits on the 16-bit data path of a NAND flash host and computes single-error-correcting Hamming parity over a 512-byte data block while the block streams through. The block is handled as two independent 256-byte halves. Each half gets 16 line-parity bits, which encode the byte position, and 6 column-parity bits, which encode the bit position within a byte. With these, software can locate and flip one bad bit in each half.

The host drives the engine by writing 8-bit codes to a mode port. One code clears the accumulators. A second code starts accumulation on each word transfer. A third code turns data-register reads into a readout of three packed 16-bit result words. A fourth code returns the data register to normal transfers. Parity is held inverted, so an erased block (all 0xFF) yields all-ones ECC bytes.

Top module: `ecc_dual_gen`

## Requirements
- R1: After reset the engine is not accumulating, every accumulator is clear, and a readout gives 16'hFFFF for all three words.
- R2: Mode code 8'hF4 clears all accumulators and the block position and stops accumulation; word transfers made before the next 8'hB4, such as the dummy read that follows a clear, are not counted.
- R3: After mode code 8'hB4, each cycle with `xfer_en` high adds one word to the parity. Bits 7:0 are the byte at the even address and bits 15:8 are the byte at the following odd address; block addresses start at 0 after a clear.
- R4: For a byte at address a within its half (8 bits), the byte's XOR parity folds into line bit 2i+1 when a[i] is 1 and into line bit 2i when a[i] is 0, for i = 0..7.
- R5: Column bits: c0 = bits 0,2,4,6; c1 = bits 1,3,5,7; c2 = bits 0,1,4,5; c3 = bits 2,3,6,7; c4 = bits 0-3; c5 = bits 4-7, each XORed over every byte of the half. The column byte carries c5..c0 in bits 7:2, and its bits 1:0 always read 1.
- R6: Bytes 0-255 feed half 0 only and bytes 256-511 feed half 1 only.
- R7: All parity bits are reported inverted, so an all-0xFF block gives all-ones result words.
- R8: Mode code 8'hD4 selects readout starting at word 0. Each `rd_en` advances the readout word 0, 1, 2 and then wraps back to 0. Word 0 = {half0 line 7:0, half0 line 15:8}, word 1 = {half1 line 7:0, half0 column byte}, word 2 = {half1 column byte, half1 line 15:8}. Outside readout, `rd_word` is 0.
- R9: Mode code 8'h94, and any code other than 8'hF4, 8'hB4 and 8'hD4, stops accumulation and leaves the accumulators unchanged; transfers made then are ignored, and accumulation resumes where it stopped after 8'hB4.
- R10: Once 512 bytes have been accumulated, further transfers are ignored until the next 8'hF4.
- R11: With one bit flipped in each half, XOR of the clean and the faulty result gives, per half, exactly one set bit in each of the 11 parity pairs. The odd members of the pairs spell out the byte address and the bit index of the flipped bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode code write strobe |
| mode_val | input | 8 | Mode code |
| xfer_en | input | 1 | One data word crosses the data path this cycle |
| xfer_word | input | 16 | Data word, low byte first in address order |
| rd_en | input | 1 | Data-register read strobe during readout |
| rd_word | output | 16 | Current result word during readout, else 0 |

## Verification
The bench builds the block with the default of 256 bytes per half. With that value the full 16-bit line parity and the exact three-word packing apply, so every result word can be compared bit for bit with a parity model written in the bench. Full 512-byte blocks with real half boundaries, overrun past the block end, and single-bit error location in both halves can all be exercised with this setting.

// File: rtl/ecc_dual_gen.sv
module ecc_dual_gen #(
  parameter int HALF_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic [7:0]  mode_val,
  input  logic        xfer_en,
  input  logic [15:0] xfer_word,
  input  logic        rd_en,
  output logic [15:0] rd_word
);
  localparam int AW  = $clog2(HALF_BYTES);
  localparam int LPW = 2 * AW;
  localparam logic [7:0] OP_CLR = 8'hF4;
  localparam logic [7:0] OP_RUN = 8'hB4;
  localparam logic [7:0] OP_OUT = 8'hD4;

  logic                      running, reading, full;
  logic [1:0]                idx;
  logic [AW-1:0]             wcnt;
  logic [1:0][LPW-1:0]       lp;
  logic [1:0][5:0]           cp;
  logic [LPW-1:0]            lp_add;
  logic [5:0]                cp_add;
  logic                      hsel;

  assign hsel = wcnt[AW-1];

  always_comb begin
    logic [7:0]    x;
    logic [AW-1:0] a;
    lp_add = '0;
    for (int b = 0; b < 2; b++) begin
      a = {wcnt[AW-2:0], 1'(b)};
      for (int i = 0; i < AW; i++) begin
        if (a[i]) lp_add[2*i+1] = lp_add[2*i+1] ^ (^xfer_word[8*b +: 8]);
        else      lp_add[2*i]   = lp_add[2*i]   ^ (^xfer_word[8*b +: 8]);
      end
    end
    x = xfer_word[7:0] ^ xfer_word[15:8];
    cp_add[0] = ^(x & 8'h55);
    cp_add[1] = ^(x & 8'hAA);
    cp_add[2] = ^(x & 8'h33);
    cp_add[3] = ^(x & 8'hCC);
    cp_add[4] = ^(x & 8'h0F);
    cp_add[5] = ^(x & 8'hF0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      reading <= 1'b0;
      full    <= 1'b0;
      idx     <= '0;
      wcnt    <= '0;
      lp      <= '0;
      cp      <= '0;
    end else if (mode_we) begin
      running <= (mode_val == OP_RUN);
      reading <= (mode_val == OP_OUT);
      idx     <= '0;
      if (mode_val == OP_CLR) begin
        full <= 1'b0;
        wcnt <= '0;
        lp   <= '0;
        cp   <= '0;
      end
    end else if (xfer_en && running && !full) begin
      lp[hsel] <= lp[hsel] ^ lp_add;
      cp[hsel] <= cp[hsel] ^ cp_add;
      wcnt     <= wcnt + 1'b1;
      full     <= (wcnt == {AW{1'b1}});
    end else if (rd_en && reading) begin
      idx <= (idx == 2'd2) ? 2'd0 : idx + 2'd1;
    end
  end

  logic [15:0] l0, l1;
  logic [7:0]  c0, c1;
  assign l0 = 16'(~lp[0]);
  assign l1 = 16'(~lp[1]);
  assign c0 = {~cp[0], 2'b11};
  assign c1 = {~cp[1], 2'b11};

  always_comb begin
    rd_word = '0;
    if (reading) begin
      case (idx)
        2'd0:    rd_word = {l0[7:0], l0[15:8]};
        2'd1:    rd_word = {l1[7:0], c0};
        2'd2:    rd_word = {c1, l1[15:8]};
        default: rd_word = '0;
      endcase
    end
  end
endmodule

// File: rtl/ecc_dual_gen_chk.sv
module ecc_dual_gen_chk #(
  parameter int LPW = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mode_we,
  input logic [7:0]          mode_val,
  input logic                rd_en,
  input logic                running,
  input logic                reading,
  input logic                full,
  input logic [1:0]          idx,
  input logic [1:0][LPW-1:0] lp,
  input logic [1:0][5:0]     cp,
  input logic [15:0]         rd_word
);
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we && mode_val == 8'hF4 |=> lp == '0 && cp == '0 && !full && !running); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !mode_we |=> $stable(lp) && $stable(cp)); // R9
  AST_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full && !mode_we |=> $stable(lp) && $stable(cp)); // R10
  AST_COL_LOW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    reading && idx == 2'd1 |-> rd_word[1:0] == 2'b11); // R5
  AST_COL_HIGH_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    reading && idx == 2'd2 |-> rd_word[9:8] == 2'b11); // R5
  AST_OUT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we && mode_val == 8'hD4 |=> reading && idx == 2'd0); // R8
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    reading && rd_en && !mode_we && idx == 2'd2 |=> idx == 2'd0); // R8
  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !reading |-> rd_word == 16'h0); // R8
endmodule

bind ecc_dual_gen ecc_dual_gen_chk #(.LPW(LPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_val(mode_val),
  .rd_en(rd_en), .running(running), .reading(reading), .full(full),
  .idx(idx), .lp(lp), .cp(cp), .rd_word(rd_word)
);

// File: tb/ecc_dual_gen_bench.sv
module ecc_dual_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [7:0]  mode_val = '0;
  logic        xfer_en = 1'b0;
  logic [15:0] xfer_word = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_word;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0]  mem [512];
  logic [15:0] ref_w [3];
  logic [15:0] got [3];

  always #2 clk = ~clk;

  ecc_dual_gen u_ecc_dual_gen (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mode(logic [7:0] code);
    @(negedge clk); mode_we = 1'b1; mode_val = code;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic push(int first, int cnt);
    for (int w = first; w < first + cnt; w++) begin
      @(negedge clk); xfer_en = 1'b1; xfer_word = {mem[2*w+1], mem[2*w]};
    end
    @(negedge clk); xfer_en = 1'b0;
  endtask

  task automatic junk(int cnt);
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk); xfer_en = 1'b1; xfer_word = 16'h5A3C ^ 16'(k * 16'h0F1);
    end
    @(negedge clk); xfer_en = 1'b0;
  endtask

  task automatic read3();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); rd_en = 1'b1; #1 got[k] = rd_word;
    end
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic compute_ref();
    logic [15:0] lpr [2];
    logic [5:0]  cpr [2];
    logic [7:0]  cb  [2];
    for (int h = 0; h < 2; h++) begin
      lpr[h] = '0; cpr[h] = '0;
      for (int a = 0; a < 256; a++) begin
        logic [7:0] d;
        d = mem[256*h + a];
        for (int i = 0; i < 8; i++)
          if (a[i]) lpr[h][2*i+1] ^= ^d; else lpr[h][2*i] ^= ^d;
        for (int c = 0; c < 8; c++)
          if (d[c])
            for (int k = 0; k < 3; k++)
              if (c[k]) cpr[h][2*k+1] ^= 1'b1; else cpr[h][2*k] ^= 1'b1;
      end
      lpr[h] = ~lpr[h];
      cb[h] = {~cpr[h], 2'b11};
    end
    ref_w[0] = {lpr[0][7:0], lpr[0][15:8]};
    ref_w[1] = {lpr[1][7:0], cb[0]};
    ref_w[2] = {cb[1], lpr[1][15:8]};
  endtask

  task automatic full_block();
    mode(8'hF4);
    junk(1);
    mode(8'hB4);
    push(0, 256);
    mode(8'hD4);
    read3();
  endtask

  task automatic fill(int seed);
    logic [15:0] s;
    s = 16'(seed) | 16'h1;
    for (int i = 0; i < 512; i++) begin
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
      mem[i] = s[7:0] ^ s[15:8];
    end
  endtask

  task automatic t_reset();
    #1 check("R8 idle output", rd_word, 16'h0);
    mode(8'hD4);
    read3();
    for (int k = 0; k < 3; k++) check("R1 reset readout", got[k], 16'hFFFF);
  endtask

  task automatic t_erased();
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    full_block();
    for (int k = 0; k < 3; k++) check("R7 erased block", got[k], 16'hFFFF);
  endtask

  task automatic t_pattern(int seed);
    fill(seed);
    compute_ref();
    full_block();
    for (int k = 0; k < 3; k++) check("R2 R3 R4 R5 pattern", got[k], ref_w[k]);
  endtask

  task automatic t_half_split();
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    mem[300] = 8'h80;
    compute_ref();
    full_block();
    check("R6 half0 untouched", got[0], 16'hFFFF);
    check("R6 half1 word1", got[1], ref_w[1]);
    check("R6 half1 word2", got[2], ref_w[2]);
    check("R6 half0 column", {8'h0, got[1][7:0]}, 16'h00FF);
  endtask

  task automatic t_pause();
    fill(77);
    compute_ref();
    mode(8'hF4);
    mode(8'hB4);
    push(0, 100);
    mode(8'h95);
    junk(5);
    mode(8'h94);
    junk(3);
    mode(8'hB4);
    push(100, 156);
    mode(8'hD4);
    read3();
    for (int k = 0; k < 3; k++) check("R9 paused accumulation", got[k], ref_w[k]);
  endtask

  task automatic t_overrun();
    fill(901);
    compute_ref();
    mode(8'hF4);
    mode(8'hB4);
    push(0, 256);
    junk(6);
    mode(8'hD4);
    read3();
    for (int k = 0; k < 3; k++) check("R10 overrun ignored", got[k], ref_w[k]);
  endtask

  task automatic t_readout();
    fill(4242);
    compute_ref();
    full_block();
    read3();
    for (int k = 0; k < 3; k++) check("R8 wrapped readout", got[k], ref_w[k]);
    mode(8'h94);
    #1 check("R8 data mode output", rd_word, 16'h0);
    junk(4);
    mode(8'hD4);
    read3();
    for (int k = 0; k < 3; k++) check("R9 kept after 94", got[k], ref_w[k]);
  endtask

  task automatic t_single_err();
    logic [15:0] clean [3];
    logic [15:0] s [3];
    logic [15:0] l0, l1;
    logic [7:0]  c0, c1, a0, a1;
    logic [2:0]  b0, b1;
    logic        ok;
    fill(555);
    full_block();
    for (int k = 0; k < 3; k++) clean[k] = got[k];
    mem[37]  = mem[37]  ^ 8'h20;
    mem[456] = mem[456] ^ 8'h04;
    full_block();
    for (int k = 0; k < 3; k++) s[k] = got[k] ^ clean[k];
    l0 = {s[0][7:0], s[0][15:8]};
    l1 = {s[2][7:0], s[1][15:8]};
    c0 = s[1][7:0];
    c1 = s[2][15:8];
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if ((l0[2*i] ^ l0[2*i+1]) != 1'b1) ok = 1'b0;
      if ((l1[2*i] ^ l1[2*i+1]) != 1'b1) ok = 1'b0;
      a0[i] = l0[2*i+1];
      a1[i] = l1[2*i+1];
    end
    for (int k = 0; k < 3; k++) begin
      if ((c0[2*k+2] ^ c0[2*k+3]) != 1'b1) ok = 1'b0;
      if ((c1[2*k+2] ^ c1[2*k+3]) != 1'b1) ok = 1'b0;
      b0[k] = c0[2*k+3];
      b1[k] = c1[2*k+3];
    end
    check("R11 pairs complementary", {15'h0, ok}, 16'h1);
    check("R11 half0 byte", {8'h0, a0}, 16'd37);
    check("R11 half0 bit", {13'h0, b0}, 16'd5);
    check("R11 half1 byte", {8'h0, a1}, 16'd200);
    check("R11 half1 bit", {13'h0, b1}, 16'd2);
    check("R11 column fixed ones", {14'h0, c0[1:0] | c1[1:0]}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_erased();
    t_pattern(1234);
    t_pattern(31337);
    t_half_split();
    t_pause();
    t_overrun();
    t_readout();
    t_single_err();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule